// File: doc/BRIEF.md
# LCD Blink and Bank-Swap Controller

This block produces the blink timing for a segment-LCD driver that runs at low multiplex rates. It divides the slow display clock by one of three programmable ratios, giving a 50%-duty blink square wave. In the hidden half of each blink period it either blanks the whole display or points the segment-waveform logic at the alternate display-RAM bank. The bank swap exists only in the drive modes that leave a spare bank free.

Two results go to the waveform generator: the effective bank select and a display-blank flag. The display-enable bit overrides everything and blanks the panel. Software can toggle that bit to get whole-display blinking at any rate it likes. The command interface, the display RAM and the backplane and segment waveform generation sit outside this block.

Top module: `lcd_blink_ctrl`

## Requirements
- R1: With `blink_mode` = 0, blinking is off. `bank_sel` equals `base_bank` and `blank` equals the inverse of `disp_en`.
- R2: `blink_mode` values 1, 2 and 3 divide the display clock by 768, 1536 and 3072 (parameter `BASE_DIV` = 768). The duty is 50%, so the visible and hidden phases last 384, 768 and 1536 clock cycles.
- R3: The first phase after a new nonzero mode is sampled is the visible phase. The hidden phase covers clock edges k = H+1 to 2H, counted from the sampling edge (k = 1), where H is the half period.
- R4: With `disp_en` = 0, `blank` is 1 in every phase and in every mode. It responds in the same cycle.
- R5: With `swap_sel` = 1 and `drive_mode` set to 0 (static) or 1 (1:2), the hidden phase drives `bank_sel` = NOT `base_bank`. `blank` then follows only `disp_en`.
- R6: With `swap_sel` = 1 and `drive_mode` set to 2 (1:3) or 3 (1:4), no spare bank exists. The hidden phase blanks the display and `bank_sel` stays at `base_bank`.
- R7: With `swap_sel` = 0, the hidden phase drives `blank` = 1 and `bank_sel` = `base_bank`.
- R8: While `rst_n` is low, the counter is cleared, the phase is visible, `blank` is 0 and `bank_sel` equals `base_bank`.
- R9: A change of `blink_mode` in the middle of a period restarts the counter. The display returns to the visible phase on the edge that samples the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blink_mode | input | 2 | Blink rate select, 0 = off |
| swap_sel | input | 1 | Blink by bank exchange instead of blanking |
| drive_mode | input | 2 | 0 static, 1 = 1:2, 2 = 1:3, 3 = 1:4 |
| disp_en | input | 1 | Display enable |
| base_bank | input | 1 | Bank selected when not swapping |
| bank_sel | output | 1 | Effective displayed bank |
| blank | output | 1 | Display blanked |

## Verification
The two outputs are combinational functions of the phase register and the current inputs. An `disp_en`, `swap_sel`, `drive_mode` or `base_bank` change therefore appears within the same cycle, and the bench samples it one time step after the negedge drive. A blink-mode change is taken on the next rising edge, counted as k = 1. The phase flips on edge H+1 and again on edge 2H+1, so each vector waits an exact number of rising edges and samples on the following falling edge. The vectors sit on both sides of every flip (k = H and k = H+1, k = 2H+1), which catches an off-by-one in the divider.

// File: rtl/lcd_blink_pkg.sv
package lcd_blink_pkg;

  typedef enum logic [1:0] {
    DRV_STATIC = 2'd0,
    DRV_MUX2   = 2'd1,
    DRV_MUX3   = 2'd2,
    DRV_MUX4   = 2'd3
  } drive_e;

  // Half blink period in display-clock cycles; mode 0 returns 1 as a harmless value.
  function automatic int unsigned half_period(input logic [1:0] mode, input int unsigned base_div);
    case (mode)
      2'd1:    half_period = base_div / 2;
      2'd2:    half_period = base_div;
      2'd3:    half_period = base_div * 2;
      default: half_period = 1;
    endcase
  endfunction

  // Only static and 1:2 drive leave an alternate RAM bank free.
  function automatic logic has_spare_bank(input logic [1:0] drive);
    has_spare_bank = (drive == DRV_STATIC) || (drive == DRV_MUX2);
  endfunction

endpackage

// File: rtl/blink_divider.sv
module blink_divider
  import lcd_blink_pkg::*;
#(
  parameter int unsigned BASE_DIV = 768,
  localparam int unsigned MAX_HALF = BASE_DIV * 2,
  localparam int unsigned CW = $clog2(MAX_HALF + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] blink_mode,
  output logic       hidden_phase,
  output logic       mode_change
);

  logic [1:0]    mode_q;
  logic [CW-1:0] cnt_q;
  logic          phase_q;
  logic [CW-1:0] half_m1;
  logic          blinking;
  logic          wrap;

  assign half_m1     = CW'(half_period(blink_mode, BASE_DIV) - 1);
  assign blinking    = (blink_mode != 2'd0);
  assign mode_change = (blink_mode != mode_q);
  assign wrap        = blinking && !mode_change && (cnt_q == half_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 2'd0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      mode_q <= blink_mode;
      if (mode_change || !blinking) begin
        cnt_q   <= '0;
        phase_q <= 1'b0;
      end else if (wrap) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign hidden_phase = phase_q;

  // R2: the counter never passes the half period of the current mode
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (blinking && !mode_change) |-> (cnt_q <= half_m1));

  // R2: the phase only flips at the end of a half period
  assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (blinking && !mode_change && cnt_q != half_m1) |=> $stable(phase_q));

  // R9: a mode change restarts in the visible phase
  assert_restart_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_change |=> (!phase_q && cnt_q == '0));

  // R1: with blinking off the phase stays visible
  assert_off_visible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!blinking && mode_q == 2'd0) |-> !phase_q);

endmodule

// File: rtl/blink_mux.sv
module blink_mux
  import lcd_blink_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hidden_phase,
  input  logic [1:0] blink_mode,
  input  logic       swap_sel,
  input  logic [1:0] drive_mode,
  input  logic       disp_en,
  input  logic       base_bank,
  output logic       bank_sel,
  output logic       blank
);

  logic hidden;
  logic swap_ok;
  logic do_swap;
  logic do_blank;

  assign hidden   = hidden_phase && (blink_mode != 2'd0);
  assign swap_ok  = swap_sel && has_spare_bank(drive_mode);
  assign do_swap  = hidden && swap_ok;
  assign do_blank = hidden && !swap_ok;

  assign bank_sel = base_bank ^ (rst_n & do_swap);
  assign blank    = rst_n & (!disp_en || do_blank);

  // R4: a disabled display is always blank
  assert_disabled_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |-> blank);

  // R6: no bank exchange in 1:3 or 1:4 drive
  assert_no_swap_mux34_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_mode[1]) |-> (bank_sel == base_bank));

  // R7: blank-style blinking never touches the bank
  assert_plain_blink_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_sel |-> (bank_sel == base_bank));

  // R8: during reset the display is not blanked and shows the base bank
  always_comb begin
    if (!rst_n) begin
      assert_reset_outputs_R8: assert (!blank && bank_sel == base_bank);
    end
  end

endmodule

// File: rtl/lcd_blink_ctrl.sv
module lcd_blink_ctrl
  import lcd_blink_pkg::*;
#(
  parameter int unsigned BASE_DIV = 768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] blink_mode,
  input  logic       swap_sel,
  input  logic [1:0] drive_mode,
  input  logic       disp_en,
  input  logic       base_bank,
  output logic       bank_sel,
  output logic       blank
);

  logic hidden_phase;
  logic mode_change;

  blink_divider #(.BASE_DIV(BASE_DIV)) u_div (
    .clk          (clk),
    .rst_n        (rst_n),
    .blink_mode   (blink_mode),
    .hidden_phase (hidden_phase),
    .mode_change  (mode_change)
  );

  blink_mux u_mux (
    .clk          (clk),
    .rst_n        (rst_n),
    .hidden_phase (hidden_phase),
    .blink_mode   (blink_mode),
    .swap_sel     (swap_sel),
    .drive_mode   (drive_mode),
    .disp_en      (disp_en),
    .base_bank    (base_bank),
    .bank_sel     (bank_sel),
    .blank        (blank)
  );

  // R5: a swapped bank never comes with blanking while enabled
  assert_swap_not_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && bank_sel != base_bank) |-> !blank);

  // R9: the cycle after a mode change is always visible
  assert_change_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_change && disp_en) |=> (disp_en && $stable(blink_mode)) |-> !blank);

endmodule

// File: tb/test_lcd_blink_ctrl.sv
module test_lcd_blink_ctrl;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] blink_mode;
  logic       swap_sel;
  logic [1:0] drive_mode;
  logic       disp_en;
  logic       base_bank;
  logic       bank_sel;
  logic       blank;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lcd_blink_ctrl i_lcd_blink_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .blink_mode (blink_mode),
    .swap_sel   (swap_sel),
    .drive_mode (drive_mode),
    .disp_en    (disp_en),
    .base_bank  (base_bank),
    .bank_sel   (bank_sel),
    .blank      (blank)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        swap;
    logic [1:0]  drive;
    logic        en;
    logic        base;
    logic [31:0] k;
    logic        exp_bank;
    logic        exp_blank;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b0, 2'd0, 1'b1, 1'b0, 32'd10,   1'b0, 1'b0}, // R3 early visible
    '{2'd1, 1'b0, 2'd0, 1'b1, 1'b0, 32'd384,  1'b0, 1'b0}, // R2 last visible edge
    '{2'd1, 1'b0, 2'd0, 1'b1, 1'b0, 32'd385,  1'b0, 1'b1}, // R2 R7 first hidden
    '{2'd2, 1'b0, 2'd0, 1'b1, 1'b0, 32'd768,  1'b0, 1'b0}, // R2 mode 2
    '{2'd2, 1'b0, 2'd0, 1'b1, 1'b0, 32'd769,  1'b0, 1'b1}, // R2 mode 2
    '{2'd3, 1'b0, 2'd1, 1'b1, 1'b0, 32'd1537, 1'b0, 1'b1}, // R2 mode 3
    '{2'd3, 1'b0, 2'd1, 1'b1, 1'b0, 32'd3073, 1'b0, 1'b0}, // R2 duty, visible again
    '{2'd1, 1'b1, 2'd0, 1'b1, 1'b0, 32'd385,  1'b1, 1'b0}, // R5 static swap
    '{2'd1, 1'b1, 2'd1, 1'b1, 1'b1, 32'd400,  1'b0, 1'b0}, // R5 1:2 swap
    '{2'd1, 1'b1, 2'd2, 1'b1, 1'b1, 32'd385,  1'b1, 1'b1}, // R6 1:3 fallback
    '{2'd2, 1'b1, 2'd3, 1'b1, 1'b0, 32'd800,  1'b0, 1'b1}, // R6 1:4 fallback
    '{2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 32'd500,  1'b1, 1'b1}, // R1 R4 off, disabled
    '{2'd0, 1'b1, 2'd0, 1'b1, 1'b1, 32'd900,  1'b1, 1'b0}, // R1 off, no swap
    '{2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 32'd10,   1'b0, 1'b1}, // R4 visible but disabled
    '{2'd1, 1'b1, 2'd0, 1'b0, 1'b1, 32'd385,  1'b0, 1'b1}  // R4 swap and disabled
  };

  task automatic check(input string req, input logic exp_bank, input logic exp_blank);
    n_checks++;
    if (bank_sel !== exp_bank || blank !== exp_blank) begin
      n_fail++;
      $display("FAIL %s: bank_sel=%b blank=%b expected bank_sel=%b blank=%b",
               req, bank_sel, blank, exp_bank, exp_blank);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; blink_mode = 2'd0; swap_sel = 1'b0; drive_mode = 2'd0;
    disp_en = 1'b1; base_bank = 1'b0;

    // R8: reset state, even with a disabled display and blinking requested
    repeat (2) @(posedge clk);
    @(negedge clk);
    blink_mode = 2'd1; disp_en = 1'b0; base_bank = 1'b1;
    #1 check("R8", 1'b1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      blink_mode = VECS[i].mode; swap_sel = VECS[i].swap; drive_mode = VECS[i].drive;
      disp_en = VECS[i].en; base_bank = VECS[i].base;
      rst_n = 1'b1;
      repeat (VECS[i].k) @(posedge clk);
      @(negedge clk);
      check($sformatf("vector %0d", i), VECS[i].exp_bank, VECS[i].exp_blank);
    end

    // R9: a mode change in the hidden phase restarts in the visible phase
    do_reset();
    blink_mode = 2'd1; swap_sel = 1'b0; drive_mode = 2'd0; disp_en = 1'b1; base_bank = 1'b0;
    rst_n = 1'b1;
    repeat (390) @(posedge clk);
    @(negedge clk);
    check("R9 hidden before change", 1'b0, 1'b1);
    blink_mode = 2'd2;
    @(posedge clk);
    @(negedge clk);
    check("R9 visible after change", 1'b0, 1'b0);
    repeat (768) @(posedge clk);
    @(negedge clk);
    check("R9 hidden at new rate", 1'b0, 1'b1);

    // R4: clearing enable blanks at once, R5: swap select applies at once
    disp_en = 1'b1; swap_sel = 1'b1;
    #1 check("R5 swap in same cycle", 1'b1, 1'b0);
    disp_en = 1'b0;
    #1 check("R4 disable in same cycle", 1'b1, 1'b1);

    // R1: returning to mode 0 clears any blink effect
    @(negedge clk);
    blink_mode = 2'd0; disp_en = 1'b1;
    #1 check("R1 off", 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule